// File: doc/BRIEF.md
# Two-Way Set-Associative Cache with Least-Recently-Used Replacement

This block is a 256-byte read/write cache placed between a processor load/store port and a slower word-wide memory. Storage is split into 8 sets. Each set holds two ways, and each way holds one four-word line with its tag and a valid flag. A request is latched and then compared against the tags of both ways of its set at the same time. A match in a valid way is a hit, and a multiplexer steers that way's word to the response. A read miss picks a victim way. An empty way is used first; otherwise the way that was not used most recently is replaced. The four words of the line are then fetched from memory in ascending order. Tag and valid are written only when the last word has arrived, and the lookup is then repeated, so it now hits. Stores are write-through: a store that hits updates the cached word and is also sent to memory. A store that misses is sent to memory only.

Control is one state machine with five states. ST_IDLE accepts a request (goes to ST_TAG). ST_TAG compares tags: a store goes to ST_STORE, a read hit goes to ST_DONE, and a read miss goes to ST_FILL. ST_FILL requests one word per memory beat and returns to ST_TAG after the fourth beat. ST_STORE holds the memory write until it is acknowledged, then goes to ST_DONE. ST_DONE raises the response for one cycle and goes back to ST_IDLE.

Top module: `cache2w`

## Requirements
- R1: The address is split as follows. Bits [3:2] select the word in the line, bits [6:4] select the set, and bits [31:7] are the tag. Bits [1:0] are ignored. A read of the same word with any byte offset returns the same data.
- R2: After reset, req_ready is 1, resp_valid is 0, and no memory request is active. Every line is invalid, so the first read of any address misses.
- R3: A read that hits responds with the cached word and makes no memory read.
- R4: A read miss makes exactly four memory reads. They cover the whole line, starting at word 0 and rising by one word per beat. The response then carries the requested word.
- R5: Two lines with the same set index and different tags can be resident together, one in each way, and both then hit.
- R6: When both ways of a set are valid, a read miss replaces the way not touched most recently. A hit or a refill counts as a touch.
- R7: When a set has an invalid way, a read miss fills that way and keeps the resident line.
- R8: A store that hits makes one memory write with the word-aligned address and the data, and no memory read. A later read of that word hits and returns the new data.
- R9: A store that misses makes one memory write and no memory read, and allocates no line. A later read of that word misses and returns the stored data from memory.
- R10: req_ready is 1 only while idle. Each accepted request gives exactly one single-cycle resp_valid pulse. Memory read and write requests are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted when req_ready is 1 |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Block is idle and can take a request |
| resp_valid | output | 1 | One-cycle pulse when the request is finished |
| resp_rdata | output | 32 | Read data, valid with resp_valid for reads |
| mem_rd_req | output | 1 | Memory read request (refill beat) |
| mem_rd_addr | output | 32 | Word-aligned address of the refill beat |
| mem_rd_valid | input | 1 | Memory read data returned this cycle |
| mem_rd_data | input | 32 | Memory read data |
| mem_wr_req | output | 1 | Memory write request (write-through) |
| mem_wr_addr | output | 32 | Word-aligned address of the memory write |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ack | input | 1 | Memory write accepted this cycle |

## Verification
The bench counts memory beats at the ports, so a hit can be told apart from a miss. It then sets up the cases below.

- Two tags share one set, and a third tag then arrives after one of the first two has been touched. A design with a stale or inverted recency bit evicts the wrong line, and a later hit shows up as four refill beats.
- Each refill beat address is checked. A design with the wrong word order or wrong field slicing fetches the wrong words or returns the wrong word.
- A store to a missing line must not allocate it. An allocating design would turn the following read into a hit.
- A store that hits must update the cached copy. A design that only writes to memory would return stale data on the read that follows.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    // Control states of the cache sequencer
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TAG   = 3'd1,
        ST_FILL  = 3'd2,
        ST_STORE = 3'd3,
        ST_DONE  = 3'd4
    } state_t;

endpackage

// File: rtl/cache2w_way.sv
// One way of the cache: valid flags, tags and line words for every set.
module cache2w_way #(
    parameter int SETS   = 8,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 25,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    // word update
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    // line state update (tag and valid)
    input  logic              set_en,
    input  logic              set_valid,
    input  logic [TAG_W-1:0]  set_tag
);

    localparam int ENTRIES = SETS * WORDS;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] word_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (set_en) begin
            valid_q[rd_idx] <= set_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[rd_idx] <= set_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_q[{rd_idx, wr_word}] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = word_q[{rd_idx, rd_word}];

endmodule

// File: rtl/cache2w_match.sv
// Parallel tag comparison over all ways of the indexed set.
module cache2w_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 25,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);

    logic [WAYS-1:0] hit_vec;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign hit_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
    end

    assign hit = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/cache2w_lru.sv
// Per-set recency bit and victim choice for a two-way cache.
module cache2w_lru #(
    parameter int SETS = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       way_valid,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim
);

    // Each bit names the way to replace next in its set.
    logic [SETS-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else if (touch_en) begin
            older_q[idx] <= ~touch_way;
        end
    end

    always_comb begin
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else begin
            victim = older_q[idx];
        end
    end

endmodule

// File: rtl/cache2w.sv
module cache2w
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);

    localparam int WAYS      = 2;
    localparam int OFF_W     = $clog2(DATA_W / 8);
    localparam int WORD_W    = $clog2(WORDS);
    localparam int IDX_W     = $clog2(SETS);
    localparam int TAG_W     = ADDR_W - IDX_W - WORD_W - OFF_W;
    localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(WORDS - 1);

    state_t state_q, state_d;

    // latched request
    logic [ADDR_W-1:0] q_addr;
    logic              q_write;
    logic [DATA_W-1:0] q_wdata;
    logic [TAG_W-1:0]  q_tag;
    logic [IDX_W-1:0]  q_idx;
    logic [WORD_W-1:0] q_word;

    logic [WORD_W-1:0] beat_q;
    logic              victim_q;
    logic [DATA_W-1:0] rdata_q;

    // way read-out
    logic [WAYS-1:0]              way_valid;
    logic [WAYS-1:0][TAG_W-1:0]   way_tag;
    logic [WAYS-1:0][DATA_W-1:0]  way_data;

    logic              hit;
    logic              hit_way;
    logic              victim;
    logic [DATA_W-1:0] hit_data;

    logic              fill_beat;
    logic              fill_last;
    logic              miss_start;
    logic              store_hit;

    assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
    assign q_idx  = q_addr[OFF_W + WORD_W +: IDX_W];
    assign q_word = q_addr[OFF_W +: WORD_W];

    assign fill_beat  = (state_q == ST_FILL) && mem_rd_valid;
    assign fill_last  = fill_beat && (beat_q == LAST_BEAT);
    assign miss_start = (state_q == ST_TAG) && !q_write && !hit;
    assign store_hit  = (state_q == ST_TAG) && q_write && hit;

    // ways, one instance each
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        logic sel_fill;
        logic sel_store;
        assign sel_fill  = (victim_q == g[0]);
        assign sel_store = (hit_way == g[0]);

        cache2w_way #(
            .SETS   (SETS),
            .WORDS  (WORDS),
            .TAG_W  (TAG_W),
            .DATA_W (DATA_W)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (q_idx),
            .rd_word   (q_word),
            .rd_valid  (way_valid[g]),
            .rd_tag    (way_tag[g]),
            .rd_data   (way_data[g]),
            .wr_en     ((fill_beat && sel_fill) || (store_hit && sel_store)),
            .wr_word   (fill_beat ? beat_q : q_word),
            .wr_data   (fill_beat ? mem_rd_data : q_wdata),
            .set_en    ((miss_start && (victim == g[0])) || (fill_last && sel_fill)),
            .set_valid (fill_last),
            .set_tag   (q_tag)
        );
    end

    cache2w_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .way_valid (way_valid),
        .way_tag   (way_tag),
        .look_tag  (q_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    assign hit_data = way_data[hit_way];

    cache2w_lru #(
        .SETS (SETS)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (q_idx),
        .way_valid (way_valid),
        .touch_en  (((state_q == ST_TAG) && hit) || fill_last),
        .touch_way (fill_last ? victim_q : hit_way),
        .victim    (victim)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_TAG;
            ST_TAG: begin
                if (q_write)  state_d = ST_STORE;
                else if (hit) state_d = ST_DONE;
                else          state_d = ST_FILL;
            end
            ST_FILL:  if (fill_last) state_d = ST_TAG;
            ST_STORE: if (mem_wr_ack) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // request, beat and response data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr   <= '0;
            q_write  <= 1'b0;
            q_wdata  <= '0;
            beat_q   <= '0;
            victim_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if ((state_q == ST_IDLE) && req_valid) begin
                q_addr  <= req_addr;
                q_write <= req_write;
                q_wdata <= req_wdata;
            end
            if (miss_start) begin
                victim_q <= victim;
                beat_q   <= '0;
            end else if (fill_beat) begin
                beat_q <= beat_q + WORD_W'(1);
            end
            if ((state_q == ST_TAG) && !q_write && hit) begin
                rdata_q <= hit_data;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        resp_valid  = (state_q == ST_DONE);
        resp_rdata  = rdata_q;
        mem_rd_req  = (state_q == ST_FILL);
        mem_rd_addr = {q_tag, q_idx, beat_q, {OFF_W{1'b0}}};
        mem_wr_req  = (state_q == ST_STORE);
        mem_wr_addr = {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wr_data = q_wdata;
    end

endmodule

module cache2w_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2,
    parameter int WORD_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              mem_wr_req,
    input logic [ADDR_W-1:0] mem_wr_addr
);

    AST_NO_DUAL_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)) else $error("dual memory request"); // R10

    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid) else $error("response longer than one cycle"); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || mem_rd_req || mem_wr_req) |-> !req_ready) else $error("ready while busy"); // R10

    AST_FILL_FROM_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_req) |-> (mem_rd_addr[OFF_W +: WORD_W] == '0)) else $error("refill not from word 0"); // R4

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid && (mem_rd_addr[OFF_W +: WORD_W] != '1)) |=>
        (mem_rd_req && (mem_rd_addr[OFF_W +: WORD_W] == $past(mem_rd_addr[OFF_W +: WORD_W]) + 1'b1)))
        else $error("refill beat order"); // R4

    AST_FILL_SAME_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && $past(mem_rd_req)) |->
        (mem_rd_addr[ADDR_W-1:OFF_W+WORD_W] == $past(mem_rd_addr[ADDR_W-1:OFF_W+WORD_W])))
        else $error("refill left its line"); // R4

    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (mem_wr_addr[OFF_W-1:0] == '0)) else $error("unaligned store"); // R8

endmodule

bind cache2w cache2w_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr)
);

// File: tb/test_cache2w.sv
module test_cache2w;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cache2w i_cache2w (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    // ---------------- memory model ----------------
    logic [31:0] stored [logic [31:0]];
    logic [31:0] rd_log [4];
    int          rd_total = 0;
    int          wr_total = 0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return {a[15:0], ~a[17:2]} ^ 32'h3C5A_0F96;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] wa;
        wa = {a[31:2], 2'b00};
        if (stored.exists(wa)) return stored[wa];
        return pattern(wa);
    endfunction

    function automatic logic [31:0] mk(input int tag, input int set, input int word);
        logic [31:0] r;
        r = {25'(tag), 3'(set), 2'(word), 2'b00};
        return r;
    endfunction

    always @(negedge clk) begin
        if (mem_rd_req) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= mem_word(mem_rd_addr);
            rd_log[rd_total % 4] <= mem_rd_addr;
            rd_total <= rd_total + 1;
        end else begin
            mem_rd_valid <= 1'b0;
        end
        if (mem_wr_req) begin
            mem_wr_ack <= 1'b1;
            stored[mem_wr_addr] = mem_wr_data;
            last_wr_addr <= mem_wr_addr;
            last_wr_data <= mem_wr_data;
            wr_total <= wr_total + 1;
        end else begin
            mem_wr_ack <= 1'b0;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one request; returns read data and memory beat counts
    task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wdata,
                          output logic [31:0] rdata, output int nrd, output int nwr, output int base);
        int rd0, wr0, n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_total;
        wr0 = wr_total;
        base = rd0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!resp_valid && n < 500) begin
            @(negedge clk);
            n++;
        end
        check("R10", "response seen", {31'd0, resp_valid}, 32'd1);
        rdata = resp_rdata;
        @(negedge clk);
        check("R10", "single pulse", {31'd0, resp_valid}, 32'd0);
        nrd = rd_total - rd0;
        nwr = wr_total - wr0;
    endtask

    task automatic rd_expect(input string req, input logic [31:0] addr, input int exp_rd);
        logic [31:0] d;
        int nrd, nwr, base;
        access(1'b0, addr, '0, d, nrd, nwr, base);
        check(req, "read beats", 32'(nrd), 32'(exp_rd));
        check(req, "read data", d, mem_word(addr));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check("R2", "ready after reset", {31'd0, req_ready}, 32'd1);
        check("R2", "no response", {31'd0, resp_valid}, 32'd0);
        check("R2", "no memory request", {30'd0, mem_rd_req, mem_wr_req}, 32'd0);
    endtask

    task automatic t_miss_fill();
        logic [31:0] d;
        int nrd, nwr, base;
        access(1'b0, mk(5, 2, 1), '0, d, nrd, nwr, base);
        check("R2", "first read misses", 32'(nrd), 32'd4);
        check("R4", "miss data", d, mem_word(mk(5, 2, 1)));
        for (int k = 0; k < 4; k++) begin
            check("R4", "beat address", rd_log[(base + k) % 4], mk(5, 2, k));
        end
        rd_expect("R3", mk(5, 2, 1), 0);
    endtask

    task automatic t_offset_words();
        rd_expect("R1", mk(5, 2, 1) + 32'd3, 0);
        rd_expect("R1", mk(5, 2, 1) + 32'd2, 0);
        for (int k = 0; k < 4; k++) begin
            rd_expect("R1", mk(5, 2, k), 0);
        end
    endtask

    task automatic t_two_ways();
        rd_expect("R7", mk(9, 2, 0), 4);      // empty way filled, tag 5 kept
        rd_expect("R7", mk(5, 2, 1), 0);
        rd_expect("R5", mk(9, 2, 3), 0);
        rd_expect("R5", mk(1, 6, 0), 4);
        rd_expect("R5", mk(2, 6, 0), 4);
        rd_expect("R5", mk(1, 6, 2), 0);
        rd_expect("R5", mk(2, 6, 2), 0);
    endtask

    task automatic t_lru();
        rd_expect("R6", mk(5, 2, 0), 0);      // touch tag 5: tag 9 now oldest
        rd_expect("R6", mk(12, 2, 0), 4);     // evicts tag 9
        rd_expect("R6", mk(5, 2, 2), 0);      // tag 5 kept
        rd_expect("R6", mk(9, 2, 0), 4);      // tag 9 gone; replaces tag 12
        rd_expect("R6", mk(5, 2, 3), 0);
        rd_expect("R6", mk(12, 2, 0), 4);     // tag 12 was the victim
    endtask

    task automatic t_store_hit();
        logic [31:0] d;
        int nrd, nwr, base;
        access(1'b1, mk(12, 2, 3) + 32'd1, 32'hDEAD_BEEF, d, nrd, nwr, base);
        check("R8", "store writes", 32'(nwr), 32'd1);
        check("R8", "store no read", 32'(nrd), 32'd0);
        check("R8", "store address", last_wr_addr, mk(12, 2, 3));
        check("R8", "store data", last_wr_data, 32'hDEAD_BEEF);
        rd_expect("R8", mk(12, 2, 3), 0);
    endtask

    task automatic t_store_miss();
        logic [31:0] d;
        int nrd, nwr, base;
        access(1'b1, mk(40, 3, 2), 32'h0BAD_F00D, d, nrd, nwr, base);
        check("R9", "store writes", 32'(nwr), 32'd1);
        check("R9", "store no read", 32'(nrd), 32'd0);
        check("R9", "memory updated", mem_word(mk(40, 3, 2)), 32'h0BAD_F00D);
        rd_expect("R9", mk(40, 3, 2), 4);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_fill();
        t_offset_words();
        t_two_ways();
        t_lru();
        t_store_hit();
        t_store_miss();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule